// File: doc/BRIEF.md
# Segment Address Translation Unit

This block converts a segmented reference, a 16-bit selector together with a 32-bit offset, into a 32-bit linear address. It holds two small on-chip descriptor tables, one global and one local, and a separate load port fills them. For each request the unit reads the selector and picks a table and an entry. It checks the access against that descriptor's type, write permission and limit. When every check passes it returns the descriptor base plus the offset. When a check fails it returns a fault with a cause code.

A long-mode input makes the base count as zero, while every check still applies. Code and data descriptors are kept apart by a type bit. An instruction fetch needs a code descriptor, and a read or write needs a data descriptor. With a flat descriptor, one with base zero and limit 0xFFFF_FFFF, the linear address equals the offset.

A small state machine tracks each response. It has two states. ST_IDLE means no response is due. ST_RESP means a response is on the outputs this cycle. Its transitions are:
- From any state, a valid request moves it to ST_RESP (T_ACCEPT).
- From any state, no request moves it to ST_IDLE (T_DRAIN).

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `rsp_valid` is 0 and every table entry is unloaded.
- R2: A request sampled with `req_valid`=1 at a clock edge gives `rsp_valid`=1 for exactly the following cycle. A cycle with no request gives `rsp_valid`=0 in the following cycle.
- R3: A request with no fault returns `rsp_lin` = base + offset, modulo 2^32. With base 0 and limit 0xFFFF_FFFF the result equals the offset.
- R4: When `long_mode`=1 the base counts as zero, so `rsp_lin` equals the offset. The type, write and limit checks still apply.
- R5: Selector decode works as follows. Bit 2 picks the local table when it is 1 and the global table when it is 0. Bits 15:3 give the entry index. Bits 1:0 do not affect the result.
- R6: A selector with index 0 and bit 2 equal to 0 is null. Any access through it faults with cause 1.
- R7: An index of 16 or more, or an entry that has not been loaded, faults with cause 2.
- R8: The access kind is encoded as 0 fetch, 1 read, 2 write, and 3 counts as a read. A fetch through a data descriptor, or a read or write through a code descriptor, faults with cause 3.
- R9: A write through a data descriptor whose writable bit is 0 faults with cause 4.
- R10: An offset greater than the limit faults with cause 5. An offset equal to the limit is allowed.
- R11: When several checks fail, only the highest-priority cause is reported. The order, highest first, is null (1), missing or out-of-range entry (2), type (3), write (4), limit (5).
- R12: On a fault `rsp_fault`=1 and `rsp_lin`=0. Without a fault `rsp_fault`=0 and `rsp_cause`=0.
- R13: When `ld_en`=1, the entry named by `ld_local` and `ld_index` takes the base, limit, code bit and writable bit given. It is then loaded. Loading the same entry again replaces its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one descriptor entry |
| ld_local | input | 1 | 1 selects the local table, 0 the global table |
| ld_index | input | 4 | Entry index being loaded |
| ld_base | input | 32 | Segment base |
| ld_limit | input | 32 | Highest valid offset |
| ld_code | input | 1 | 1 marks a code descriptor, 0 a data descriptor |
| ld_writable | input | 1 | Writes allowed; applies to data descriptors only |
| req_valid | input | 1 | Translation request present |
| req_sel | input | 16 | Selector |
| req_off | input | 32 | Offset into the segment |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| long_mode | input | 1 | Count the base as zero |
| rsp_valid | output | 1 | Response valid |
| rsp_lin | output | 32 | Linear address, 0 on a fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 3 | Fault cause, 0 when there is no fault |

## Verification
A wrong decode of bit 2 or of the index reads the wrong entry. It shows up in the very next response, either as the wrong base in `rsp_lin` or as an unexpected cause 2. Errors in the table contents or the load port stay hidden until a request hits the damaged entry. The bench therefore reads every entry it loads, and reads one entry again after reloading it. An error in the check order shows only when several checks fail at once, so there are requests that fail more than one check in a single response. A state machine that gets stuck breaks the one-cycle `rsp_valid` pulse on the first idle cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_NULL  = 3'd1,
        FLT_ENTRY = 3'd2,
        FLT_TYPE  = 3'd3,
        FLT_WRITE = 3'd4,
        FLT_LIMIT = 3'd5
    } fault_cause_e;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        logic        is_code;
        logic        writable;
        logic        loaded;
    } seg_desc_t;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc
);

    seg_desc_t entries [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                entries[i] <= '0;
            end
        end else if (wr_en) begin
            entries[wr_idx] <= wr_desc;
        end
    end

    assign rd_desc = entries[rd_idx];

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_xlate_pkg::*;
(
    input  seg_desc_t    desc,
    input  logic         is_null,
    input  logic         idx_oob,
    input  logic [1:0]   kind,
    input  logic [31:0]  offset,
    input  logic         long_mode,
    output fault_cause_e cause,
    output logic [31:0]  lin_addr
);

    logic want_code;
    logic is_write;
    logic [31:0] eff_base;

    always_comb begin
        want_code = (kind == ACC_FETCH);
        is_write  = (kind == ACC_WRITE);
        eff_base  = long_mode ? 32'd0 : desc.base;

        if (is_null) begin
            cause = FLT_NULL;
        end else if (idx_oob || !desc.loaded) begin
            cause = FLT_ENTRY;
        end else if (want_code != desc.is_code) begin
            cause = FLT_TYPE;
        end else if (is_write && !desc.writable) begin
            cause = FLT_WRITE;
        end else if (offset > desc.limit) begin
            cause = FLT_LIMIT;
        end else begin
            cause = FLT_NONE;
        end

        lin_addr = (cause == FLT_NONE) ? (eff_base + offset) : 32'd0;
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int TBL_DEPTH = 16,
    localparam int IDX_W     = $clog2(TBL_DEPTH),
    localparam int SEL_IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_local,
    input  logic [IDX_W-1:0] ld_index,
    input  logic [31:0]      ld_base,
    input  logic [31:0]      ld_limit,
    input  logic             ld_code,
    input  logic             ld_writable,
    input  logic             req_valid,
    input  logic [15:0]      req_sel,
    input  logic [31:0]      req_off,
    input  logic [1:0]       req_kind,
    input  logic             long_mode,
    output logic             rsp_valid,
    output logic [31:0]      rsp_lin,
    output logic             rsp_fault,
    output logic [2:0]       rsp_cause
);

    typedef enum logic {ST_IDLE, ST_RESP} rsp_state_e;

    rsp_state_e state_q, state_d;

    logic [SEL_IDX_W-1:0] sel_idx;
    logic                 sel_local;
    logic [1:0]           unused_rpl;
    logic                 sel_null;
    logic                 sel_oob;
    seg_desc_t            ld_desc;
    seg_desc_t            tbl_out [2];
    seg_desc_t            hit_desc;
    fault_cause_e         chk_cause;
    logic [31:0]          chk_lin;
    logic [31:0]          lin_q;
    fault_cause_e         cause_q;

    assign sel_idx    = req_sel[15:3];
    assign sel_local  = req_sel[2];
    assign unused_rpl = req_sel[1:0];
    assign sel_null   = !sel_local && (sel_idx == '0);
    assign sel_oob    = sel_idx >= SEL_IDX_W'(TBL_DEPTH);

    assign ld_desc = '{base: ld_base, limit: ld_limit, is_code: ld_code,
                       writable: ld_writable, loaded: 1'b1};

    // Index 0 holds the global table, index 1 the local table.
    for (genvar t = 0; t < 2; t++) begin : g_tbl
        seg_desc_table #(.DEPTH(TBL_DEPTH)) tbl_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ld_en && (ld_local == t[0])),
            .wr_idx  (ld_index),
            .wr_desc (ld_desc),
            .rd_idx  (sel_idx[IDX_W-1:0]),
            .rd_desc (tbl_out[t])
        );
    end

    assign hit_desc = sel_local ? tbl_out[1] : tbl_out[0];

    seg_access_check chk_i (
        .desc      (hit_desc),
        .is_null   (sel_null),
        .idx_oob   (sel_oob),
        .kind      (req_kind),
        .offset    (req_off),
        .long_mode (long_mode),
        .cause     (chk_cause),
        .lin_addr  (chk_lin)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lin_q   <= '0;
            cause_q <= FLT_NONE;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                lin_q   <= chk_lin;
                cause_q <= chk_cause;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_lin   = '0;
        rsp_fault = 1'b0;
        rsp_cause = FLT_NONE;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_lin   = lin_q;
                rsp_fault = (cause_q != FLT_NONE);
                rsp_cause = cause_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [15:0] req_sel,
    input logic [31:0] req_off,
    input logic        long_mode,
    input logic        rsp_valid,
    input logic [31:0] rsp_lin,
    input logic        rsp_fault,
    input logic [2:0]  rsp_cause
);

    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_null_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel[15:2] == 14'd0) |=> (rsp_fault && rsp_cause == 3'd1));

    p_index_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel[15:7] != 9'd0) |=> (rsp_fault && rsp_cause == 3'd2));

    p_long_flat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_mode) |=> (rsp_fault || rsp_lin == $past(req_off)));

    p_fault_zero_lin_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_lin == 32'd0 && rsp_cause != 3'd0));

    p_ok_no_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 3'd0));

    p_cause_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_cause <= 3'd5));

endmodule

bind seg_xlate_unit seg_xlate_chk chk_bind_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .req_off   (req_off),
    .long_mode (long_mode),
    .rsp_valid (rsp_valid),
    .rsp_lin   (rsp_lin),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_local = 1'b0;
    logic [3:0]  ld_index = '0;
    logic [31:0] ld_base = '0;
    logic [31:0] ld_limit = '0;
    logic        ld_code = 1'b0;
    logic        ld_writable = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_kind = '0;
    logic        long_mode = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_lin;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    seg_xlate_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_local(ld_local), .ld_index(ld_index),
        .ld_base(ld_base), .ld_limit(ld_limit), .ld_code(ld_code),
        .ld_writable(ld_writable),
        .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
        .req_kind(req_kind), .long_mode(long_mode),
        .rsp_valid(rsp_valid), .rsp_lin(rsp_lin), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause)
    );

    task automatic load(input bit loc, input int idx, input logic [31:0] base,
                        input logic [31:0] lim, input bit code, input bit wr);
        @(negedge clk);
        ld_en = 1'b1; ld_local = loc; ld_index = idx[3:0];
        ld_base = base; ld_limit = lim; ld_code = code; ld_writable = wr;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Drive one request; the response is registered at the next edge
    // and sampled at the falling edge after it.
    task automatic xlate(input string tag, input logic [15:0] sel,
                         input logic [31:0] off, input logic [1:0] kind,
                         input bit lm, input logic [2:0] exp_cause,
                         input logic [31:0] exp_lin);
        logic [31:0] want_lin;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_off = off;
        req_kind = kind; long_mode = lm;
        @(negedge clk);
        req_valid = 1'b0;
        want_lin = (exp_cause != 3'd0) ? 32'd0 : exp_lin;
        tests++;
        if (rsp_valid !== 1'b1 || rsp_cause !== exp_cause ||
            rsp_fault !== (exp_cause != 3'd0) || rsp_lin !== want_lin) begin
            fails++;
            $display("FAIL %s: valid=%0b cause=%0d lin=%h, expected valid=1 cause=%0d lin=%h",
                     tag, rsp_valid, rsp_cause, rsp_lin, exp_cause, want_lin);
        end
    endtask

    task automatic t_reset();
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: rsp_valid=%0b expected 0", rsp_valid);
        end
        // R1: no entry loaded yet
        xlate("R1 unloaded after reset", 16'h0008, 32'h0, 2'd1, 1'b0, 3'd2, 32'h0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 idle cycle: rsp_valid=%0b expected 0", rsp_valid);
        end
    endtask

    task automatic t_translate();
        load(1'b0, 1, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b1);
        xlate("R3 flat", 16'h0008, 32'h1234_5678, 2'd1, 1'b0, 3'd0, 32'h1234_5678);
        load(1'b0, 2, 32'h1000_0000, 32'h0000_FFFF, 1'b0, 1'b0);
        xlate("R3 based read", 16'h0010, 32'h20, 2'd1, 1'b0, 3'd0, 32'h1000_0020);
        xlate("R8 kind 3 as read", 16'h0010, 32'h24, 2'd3, 1'b0, 3'd0, 32'h1000_0024);
        load(1'b0, 3, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 1'b0, 1'b1);
        xlate("R3 wrap", 16'h0018, 32'h20, 2'd2, 1'b0, 3'd0, 32'h0000_0010);
    endtask

    task automatic t_limit_perm();
        xlate("R10 offset at limit", 16'h0010, 32'hFFFF, 2'd1, 1'b0, 3'd0, 32'h1000_FFFF);
        xlate("R10 offset past limit", 16'h0010, 32'h1_0000, 2'd1, 1'b0, 3'd5, 32'h0);
        xlate("R9 write read-only", 16'h0010, 32'h20, 2'd2, 1'b0, 3'd4, 32'h0);
        xlate("R11 write+limit", 16'h0010, 32'h1_0000, 2'd2, 1'b0, 3'd4, 32'h0);
    endtask

    task automatic t_local_type();
        load(1'b1, 2, 32'h4000_0000, 32'h000F_FFFF, 1'b1, 1'b0);
        xlate("R5 local code fetch", 16'h0017, 32'h100, 2'd0, 1'b0, 3'd0, 32'h4000_0100);
        xlate("R5 rpl ignored", 16'h0014, 32'h100, 2'd0, 1'b0, 3'd0, 32'h4000_0100);
        xlate("R8 fetch from data", 16'h0010, 32'h20, 2'd0, 1'b0, 3'd3, 32'h0);
        xlate("R8 read from code", 16'h0014, 32'h20, 2'd1, 1'b0, 3'd3, 32'h0);
        xlate("R11 code write over limit", 16'h0014, 32'h0010_0000, 2'd2, 1'b0, 3'd3, 32'h0);
    endtask

    task automatic t_null_entry();
        xlate("R6 null selector", 16'h0003, 32'h0, 2'd1, 1'b0, 3'd1, 32'h0);
        xlate("R11 null beats type", 16'h0000, 32'h0, 2'd0, 1'b1, 3'd1, 32'h0);
        xlate("R7 local index 0 unloaded", 16'h0004, 32'h0, 2'd1, 1'b0, 3'd2, 32'h0);
        xlate("R7 index 16", 16'h0080, 32'h0, 2'd1, 1'b0, 3'd2, 32'h0);
        xlate("R7 global index 5 unloaded", 16'h0028, 32'h0, 2'd0, 1'b0, 3'd2, 32'h0);
    endtask

    task automatic t_long();
        xlate("R4 long base zero", 16'h0010, 32'h20, 2'd1, 1'b1, 3'd0, 32'h20);
        xlate("R4 long limit kept", 16'h0010, 32'h1_0000, 2'd1, 1'b1, 3'd5, 32'h0);
        xlate("R4 long type kept", 16'h0010, 32'h20, 2'd0, 1'b1, 3'd3, 32'h0);
    endtask

    task automatic t_reload();
        load(1'b0, 2, 32'h2000_0000, 32'h0000_FFFF, 1'b0, 1'b1);
        xlate("R13 reload base", 16'h0010, 32'h20, 2'd2, 1'b0, 3'd0, 32'h2000_0020);
        xlate("R13 global 1 untouched", 16'h0009, 32'h40, 2'd1, 1'b0, 3'd0, 32'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_translate();
        t_limit_perm();
        t_local_type();
        t_null_entry();
        t_long();
        t_reload();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule